// File: doc/BRIEF.md
# GPIO Port with Grouped Interrupts

This block is a 32-pin general-purpose I/O port controlled through a simple word-addressed register interface. Each pin is an input or an output under a direction register. Input pins are brought through a two-flop synchroniser and an optional inversion before they land in a shared value register. Output pins take their value from software, either by a whole-word write or by atomic set and clear strobes that touch only output bits.

Whenever an input pin's stored value goes from 0 to 1, its cause bit is latched. The pins are split into four groups of eight. Each group drives one interrupt line toward a main interrupt collector, and that line rises when a masked-in pin of the group rises. A global mode bit selects how a line is released. In edge mode, software releases it by rewriting the cause register. In level mode, it is released when the group's input values all fall back to zero.

Top module: `gpio_grp_port`

## Requirements
- R1: After reset every register holds 0: all pins are inputs (pin_oe = 0), the port is in edge mode, and all group interrupts are low.
- R2: Direction bit 1 makes a pin an output. pin_oe equals the direction register (offset 0x0), and pin_out equals the value register (offset 0x2).
- R3: Writes to value (0x2), set (0x3) and clear (0x4) change only bits whose direction bit is 1. Set ORs the written bits into the value, and clear removes them. Set and clear always read back as 0.
- R4: For an input pin, the value register takes the pin level XOR the polarity bit (offset 0x1). The new value appears on pin_out on the third rising clock edge after the pin changes.
- R5: When an input pin's stored value rises from 0 to 1, its bit in the cause register (0x5) is set. If the pin's mask bit is also 1, group interrupt pin/8 is raised on the same edge.
- R6: In level mode, an input pin whose value falls releases its group interrupt once all eight value bits of that group are 0. Cause-register writes then only store the new cause value.
- R7: In edge mode, a write stores the cause register. Each group whose cause bits changed and are now all 0 has its interrupt released. Falling pin values never release an interrupt in this mode.
- R8: Bit 10 of the control register (0x8) is the mode bit (1 = level). Its other written bits are ignored, and it reads as 0x11FF0000 OR (mode << 10).
- R9: Offsets 0x6 and 0x7 both read and write one shared 32-bit mask register.
- R10: Read data appears on bus_rdata one clock after the read strobe. Unmapped offsets (0x9 to 0xF) read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Value register driven to the pads |
| pin_oe | output | 32 | Per-pin output enable (direction) |
| grp_irq | output | 4 | One interrupt line per group of eight pins |

## Verification
The assertions assume reset is applied before the first access, and that each cycle carries at most one register write. They also take bus_addr to be stable while a strobe is high. The bench drives every input on the falling edge and issues one access per strobe. It holds pin levels for several cycles, so each change passes the synchroniser before the next change is made. The model therefore sees each rise or fall as a single event, and the checks on same-cycle set and release decisions stay meaningful.

// File: rtl/gpio_grp_pkg.sv
`timescale 1ns/1ps
package gpio_grp_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RG_DIR      = 4'h0,
    RG_POL      = 4'h1,
    RG_VAL      = 4'h2,
    RG_SET      = 4'h3,
    RG_CLR      = 4'h4,
    RG_CAUSE    = 4'h5,
    RG_MASK     = 4'h6,
    RG_MASK_ALT = 4'h7,
    RG_CTRL     = 4'h8
  } reg_sel_e;

  localparam logic [BUS_W-1:0] CTRL_FIXED = 32'h11FF_0000;
  localparam int               MODE_BIT   = 10;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for asynchronous pin levels.
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_core.sv
`timescale 1ns/1ps
// Value and cause storage; detects input-driven rising and falling values.
module gpio_pin_core #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] dir,
  input  logic [NUM_PINS-1:0] pol,
  input  logic [NUM_PINS-1:0] sync_in,
  input  logic [NUM_PINS-1:0] wdata,
  input  logic                val_wr,
  input  logic                set_wr,
  input  logic                clr_wr,
  input  logic                cause_wr,
  output logic [NUM_PINS-1:0] value_q,
  output logic [NUM_PINS-1:0] cause_q,
  output logic [NUM_PINS-1:0] rise,
  output logic [NUM_PINS-1:0] fall,
  output logic [NUM_PINS-1:0] value_nxt
);
  logic [NUM_PINS-1:0] sampled;
  logic [NUM_PINS-1:0] sw_val;

  always_comb begin
    sampled = sync_in ^ pol;
    rise    = ~dir & sampled & ~value_q;
    fall    = ~dir & ~sampled & value_q;
    sw_val  = value_q;
    if (val_wr) sw_val = wdata;
    if (set_wr) sw_val = value_q | wdata;
    if (clr_wr) sw_val = value_q & ~wdata;
    // outputs keep the software value, inputs follow the sampled level
    value_nxt = (dir & sw_val) | (~dir & sampled);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
      cause_q <= '0;
    end else begin
      value_q <= value_nxt;
      cause_q <= (cause_wr ? wdata : cause_q) | rise;
    end
  end
endmodule

// File: rtl/gpio_grp_irq.sv
`timescale 1ns/1ps
// One interrupt flop per pin group; raising has priority over release.
module gpio_grp_irq #(
  parameter int NUM_PINS   = 32,
  parameter int GROUP_SIZE = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           level_mode,
  input  logic [NUM_PINS-1:0]            mask,
  input  logic [NUM_PINS-1:0]            rise,
  input  logic [NUM_PINS-1:0]            fall,
  input  logic [NUM_PINS-1:0]            value_nxt,
  input  logic [NUM_PINS-1:0]            cause_q,
  input  logic [NUM_PINS-1:0]            wdata,
  input  logic                           cause_wr,
  output logic [NUM_PINS/GROUP_SIZE-1:0] irq
);
  localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic raise_g;
    logic release_g;
    logic [GROUP_SIZE-1:0] cause_old;
    logic [GROUP_SIZE-1:0] cause_new;

    always_comb begin
      cause_old = cause_q[g*GROUP_SIZE +: GROUP_SIZE];
      cause_new = wdata[g*GROUP_SIZE +: GROUP_SIZE];
      raise_g   = |(rise[g*GROUP_SIZE +: GROUP_SIZE] & mask[g*GROUP_SIZE +: GROUP_SIZE]);
      if (level_mode)
        release_g = (|fall[g*GROUP_SIZE +: GROUP_SIZE]) &&
                    (value_nxt[g*GROUP_SIZE +: GROUP_SIZE] == '0);
      else
        release_g = cause_wr && ((cause_old ^ cause_new) != '0) && (cause_new == '0);
    end

    always_ff @(posedge clk) begin
      if (rst)            irq[g] <= 1'b0;
      else if (raise_g)   irq[g] <= 1'b1;
      else if (release_g) irq[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_grp_port.sv
`timescale 1ns/1ps
// GPIO port top: register file, address decode, readback and submodule wiring.
module gpio_grp_port
  import gpio_grp_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int GROUP_SIZE  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [BUS_W-1:0]               bus_wdata,
  output logic [BUS_W-1:0]               bus_rdata,
  input  logic [NUM_PINS-1:0]            pin_in,
  output logic [NUM_PINS-1:0]            pin_out,
  output logic [NUM_PINS-1:0]            pin_oe,
  output logic [NUM_PINS/GROUP_SIZE-1:0] grp_irq
);
  logic [NUM_PINS-1:0] dir_q, pol_q, mask_q;
  logic                mode_q;
  logic [NUM_PINS-1:0] wd;
  logic [NUM_PINS-1:0] sync_in;
  logic [NUM_PINS-1:0] value_q, cause_q, rise, fall, value_nxt;
  logic                wr_dir, wr_pol, wr_val, wr_set, wr_clr, wr_cause, wr_mask, wr_ctrl;
  logic [BUS_W-1:0]    rd_mux;

  assign wd = bus_wdata[NUM_PINS-1:0];

  always_comb begin
    wr_dir = 1'b0; wr_pol = 1'b0; wr_val = 1'b0; wr_set = 1'b0;
    wr_clr = 1'b0; wr_cause = 1'b0; wr_mask = 1'b0; wr_ctrl = 1'b0;
    if (bus_wr) begin
      case (bus_addr)
        RG_DIR:               wr_dir   = 1'b1;
        RG_POL:               wr_pol   = 1'b1;
        RG_VAL:               wr_val   = 1'b1;
        RG_SET:               wr_set   = 1'b1;
        RG_CLR:               wr_clr   = 1'b1;
        RG_CAUSE:             wr_cause = 1'b1;
        RG_MASK, RG_MASK_ALT: wr_mask  = 1'b1;
        RG_CTRL:              wr_ctrl  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      pol_q  <= '0;
      mask_q <= '0;
      mode_q <= 1'b0;
    end else begin
      if (wr_dir)  dir_q  <= wd;
      if (wr_pol)  pol_q  <= wd;
      if (wr_mask) mask_q <= wd;
      if (wr_ctrl) mode_q <= bus_wdata[MODE_BIT];
    end
  end

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (sync_in)
  );

  gpio_pin_core #(.NUM_PINS(NUM_PINS)) core_i (
    .clk       (clk),
    .rst       (rst),
    .dir       (dir_q),
    .pol       (pol_q),
    .sync_in   (sync_in),
    .wdata     (wd),
    .val_wr    (wr_val),
    .set_wr    (wr_set),
    .clr_wr    (wr_clr),
    .cause_wr  (wr_cause),
    .value_q   (value_q),
    .cause_q   (cause_q),
    .rise      (rise),
    .fall      (fall),
    .value_nxt (value_nxt)
  );

  gpio_grp_irq #(.NUM_PINS(NUM_PINS), .GROUP_SIZE(GROUP_SIZE)) irq_i (
    .clk        (clk),
    .rst        (rst),
    .level_mode (mode_q),
    .mask       (mask_q),
    .rise       (rise),
    .fall       (fall),
    .value_nxt  (value_nxt),
    .cause_q    (cause_q),
    .wdata      (wd),
    .cause_wr   (wr_cause),
    .irq        (grp_irq)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      RG_DIR:               rd_mux[NUM_PINS-1:0] = dir_q;
      RG_POL:               rd_mux[NUM_PINS-1:0] = pol_q;
      RG_VAL:               rd_mux[NUM_PINS-1:0] = value_q;
      RG_CAUSE:             rd_mux[NUM_PINS-1:0] = cause_q;
      RG_MASK, RG_MASK_ALT: rd_mux[NUM_PINS-1:0] = mask_q;
      RG_CTRL: begin
        rd_mux           = CTRL_FIXED;
        rd_mux[MODE_BIT] = mode_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign pin_out = value_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_grp_port_chk.sv
`timescale 1ns/1ps
module gpio_grp_port_chk
  import gpio_grp_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int GROUP_SIZE = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           bus_wr,
  input logic                           bus_rd,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [BUS_W-1:0]               bus_wdata,
  input logic [BUS_W-1:0]               bus_rdata,
  input logic [NUM_PINS-1:0]            pin_out,
  input logic [NUM_PINS-1:0]            pin_oe,
  input logic [NUM_PINS/GROUP_SIZE-1:0] grp_irq,
  input logic                           mode,
  input logic [NUM_PINS-1:0]            cause
);
  localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE;

  // R3: strobe registers read back as zero
  a_r3_strobe_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == RG_SET || bus_addr == RG_CLR)) |=> (bus_rdata == '0));

  // R3: a value write lands on output pins exactly
  a_r3_val_write_outputs: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == RG_VAL) |=>
      ((pin_out & $past(pin_oe)) == ($past(bus_wdata[NUM_PINS-1:0]) & $past(pin_oe))));

  // R8: control readback has the fixed pattern outside the mode bit
  a_r8_ctrl_pattern: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == RG_CTRL) |=> ((bus_rdata & ~(32'h1 << MODE_BIT)) == CTRL_FIXED));

  // R7: in edge mode, no interrupt is released without a cause write
  a_r7_edge_hold: assert property (@(posedge clk) disable iff (rst)
    (!mode && !(bus_wr && bus_addr == RG_CAUSE)) |=> (($past(grp_irq) & ~grp_irq) == '0));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    // R5: a raised group always has a latched cause bit
    a_r5_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(grp_irq[g]) |-> (cause[g*GROUP_SIZE +: GROUP_SIZE] != '0));

    // R6: in level mode a group releases only when its values are all zero
    a_r6_level_release: assert property (@(posedge clk) disable iff (rst)
      ($fell(grp_irq[g]) && $past(mode)) |-> (pin_out[g*GROUP_SIZE +: GROUP_SIZE] == '0));
  end
endmodule

bind gpio_grp_port gpio_grp_port_chk #(.NUM_PINS(NUM_PINS), .GROUP_SIZE(GROUP_SIZE)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .grp_irq   (grp_irq),
  .mode      (mode_q),
  .cause     (cause_q)
);

// File: tb/gpio_grp_port_tb_top.sv
`timescale 1ns/1ps
module gpio_grp_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pin_in = '0, pin_out, pin_oe;
  logic [3:0]  grp_irq;

  int checks = 0, errors = 0, cyc = 0;
  bit armed = 0;

  always #2.5 clk = ~clk;

  gpio_grp_port dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .grp_irq(grp_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_dir, m_pol, m_val, m_cause, m_mask, m_s1, m_s2, m_rd;
  logic        m_mode;
  logic [3:0]  m_irq;

  function automatic logic [7:0] grp(input logic [31:0] v, input int g);
    return 8'((v >> (g * 8)) & 32'hFF);
  endfunction

  function automatic logic [31:0] mread(input logic [3:0] a);
    case (a)
      4'h0: return m_dir;
      4'h1: return m_pol;
      4'h2: return m_val;
      4'h5: return m_cause;
      4'h6, 4'h7: return m_mask;
      4'h8: return 32'h11FF0000 | (32'(m_mode) << 10);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [31:0] smp, nv, nc, rs, fl;
    logic [3:0]  ni;
    if (rst) begin
      m_dir = 0; m_pol = 0; m_val = 0; m_cause = 0; m_mask = 0; m_mode = 0;
      m_irq = 0; m_s1 = 0; m_s2 = 0; m_rd = 0;
    end else begin
      smp = m_s2 ^ m_pol; nv = m_val; nc = m_cause; ni = m_irq; rs = 0; fl = 0;
      for (int p = 0; p < 32; p++) begin
        if (!m_dir[p]) begin
          if (smp[p] && !m_val[p]) rs[p] = 1'b1;
          if (!smp[p] && m_val[p]) fl[p] = 1'b1;
          nv[p] = smp[p];
        end
      end
      if (bus_rd) m_rd = mread(bus_addr);
      if (bus_wr) begin
        case (bus_addr)
          4'h2: nv = (nv & ~m_dir) | (bus_wdata & m_dir);
          4'h3: nv = nv | (bus_wdata & m_dir);
          4'h4: nv = nv & ~(bus_wdata & m_dir);
          4'h5: begin
            nc = bus_wdata;
            if (!m_mode)
              for (int g = 0; g < 4; g++)
                if (grp(m_cause ^ bus_wdata, g) != 0 && grp(bus_wdata, g) == 0) ni[g] = 1'b0;
          end
          default: ;
        endcase
      end
      if (m_mode)
        for (int g = 0; g < 4; g++)
          if (grp(fl, g) != 0 && grp(nv, g) == 0) ni[g] = 1'b0;
      nc = nc | rs;
      for (int g = 0; g < 4; g++)
        if (grp(rs & m_mask, g) != 0) ni[g] = 1'b1;
      if (bus_wr) begin
        case (bus_addr)
          4'h0: m_dir = bus_wdata;
          4'h1: m_pol = bus_wdata;
          4'h6, 4'h7: m_mask = bus_wdata;
          4'h8: m_mode = bus_wdata[10];
          default: ;
        endcase
      end
      m_val = nv; m_cause = nc; m_irq = ni;
      m_s2 = m_s1; m_s1 = pin_in;
    end
    armed = 1;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (armed && !rst) begin
      chk("R2 pin_out vs model", pin_out, m_val);
      chk("R2 pin_oe vs model", pin_oe, m_dir);
      chk("R5 grp_irq vs model", {28'h0, grp_irq}, {28'h0, m_irq});
      chk("R10 rdata vs model", bus_rdata, m_rd);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setin(input logic [31:0] d);
    @(negedge clk); pin_in = d;
  endtask

  logic [31:0] r;

  initial begin
    idle(4);
    rst = 0;
    // R1 reset state
    rd(4'h0, r); chk("R1 dir after reset", r, 32'h0);
    rd(4'h8, r); chk("R1 R8 ctrl after reset", r, 32'h11FF0000);
    chk("R1 oe after reset", pin_oe, 32'h0);
    chk("R1 irq after reset", {28'h0, grp_irq}, 32'h0);

    // R2 / R3 output handling
    wr(4'h0, 32'h0000FFFF);
    wr(4'h2, 32'hFFFFFFFF);
    rd(4'h2, r); chk("R3 value write only outputs", r, 32'h0000FFFF);
    chk("R2 oe follows dir", pin_oe, 32'h0000FFFF);
    chk("R2 pin_out follows value", pin_out, 32'h0000FFFF);
    wr(4'h4, 32'hFF00FF00);
    rd(4'h2, r); chk("R3 clear only outputs", r, 32'h000000FF);
    wr(4'h3, 32'h00F00300);
    rd(4'h2, r); chk("R3 set only outputs", r, 32'h000003FF);
    rd(4'h3, r); chk("R3 set reads zero", r, 32'h0);
    rd(4'h4, r); chk("R3 clear reads zero", r, 32'h0);
    wr(4'h2, 32'h0);
    wr(4'h0, 32'h0);

    // R4 synchroniser latency
    @(negedge clk); pin_in = 32'h1;
    @(negedge clk); @(negedge clk);
    chk("R4 value not yet visible", {31'h0, pin_out[0]}, 32'h0);
    @(negedge clk);
    chk("R4 value on third edge", {31'h0, pin_out[0]}, 32'h1);
    idle(2);
    rd(4'h2, r); chk("R4 value readback", r, 32'h1);
    rd(4'h5, r); chk("R5 cause latched", r, 32'h1);
    chk("R5 unmasked no irq", {28'h0, grp_irq}, 32'h0);

    // R4 polarity inversion
    wr(4'h1, 32'h00000100);
    idle(2);
    rd(4'h5, r); chk("R4 inverted pin rises", r, 32'h00000101);

    // R9 shared mask
    wr(4'h7, 32'h00000200);
    rd(4'h6, r); chk("R9 alias write primary read", r, 32'h00000200);
    wr(4'h6, 32'h80000200);
    rd(4'h7, r); chk("R9 primary write alias read", r, 32'h80000200);

    // R5 masked rise
    setin(32'h00000201); idle(4);
    chk("R5 group1 raised", {28'h0, grp_irq}, 32'h2);
    rd(4'h5, r); chk("R5 cause bits", r, 32'h00000301);

    // R7 edge mode
    setin(32'h00000001); idle(4);
    chk("R7 fall does not release", {28'h0, grp_irq}, 32'h2);
    wr(4'h5, 32'h00000001);
    chk("R7 cause write releases group", {28'h0, grp_irq}, 32'h0);
    rd(4'h5, r); chk("R7 cause stored", r, 32'h1);
    setin(32'h00000201); idle(4);
    chk("R7 raised again", {28'h0, grp_irq}, 32'h2);
    wr(4'h5, 32'h00000200);
    chk("R7 unchanged group kept", {28'h0, grp_irq}, 32'h2);

    // R8 / R6 level mode
    wr(4'h8, 32'hFFFFFFFF);
    rd(4'h8, r); chk("R8 ctrl level readback", r, 32'h11FF0400);
    setin(32'h00000001); idle(4);
    chk("R6 group not all zero keeps irq", {28'h0, grp_irq}, 32'h2);
    wr(4'h5, 32'h0);
    chk("R6 cause write no release", {28'h0, grp_irq}, 32'h2);
    rd(4'h5, r); chk("R6 cause stored in level mode", r, 32'h0);
    wr(4'h1, 32'h0);
    idle(3);
    chk("R6 last value falls releases", {28'h0, grp_irq}, 32'h0);
    setin(32'h80000001); idle(4);
    chk("R5 group3 raised", {28'h0, grp_irq}, 32'h8);
    setin(32'h00000001); idle(4);
    chk("R6 group3 released", {28'h0, grp_irq}, 32'h0);

    // R10 unmapped offsets
    rd(4'hF, r); chk("R10 unmapped reads zero", r, 32'h0);
    wr(4'hF, 32'hFFFFFFFF);
    rd(4'h0, r); chk("R10 unmapped write no dir change", r, 32'h0);
    rd(4'h1, r); chk("R10 unmapped write no pol change", r, 32'h0);

    // R1 reset mid-run
    wr(4'h0, 32'h000000F0);
    @(negedge clk); rst = 1;
    idle(3);
    rst = 0;
    @(negedge clk);
    chk("R1 oe cleared by reset", pin_oe, 32'h0);
    chk("R1 irq cleared by reset", {28'h0, grp_irq}, 32'h0);
    rd(4'h8, r); chk("R1 edge mode after reset", r, 32'h11FF0000);
    rd(4'h6, r); chk("R1 mask after reset", r, 32'h0);

    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule